// File: doc/BRIEF.md
# ATM transmit cell intake with odd-parity monitor

This block sits behind an 8-bit cell transmit bus. An ATM-layer device drives the bus from its own free-running clock, and the block uses that clock throughout. A byte counts as presented on any clock edge where the device holds its enable high. A start-of-cell flag marks byte 0 of each 53-byte cell.

Presented bytes are written into slots of a cell queue. A slot only becomes visible to the downstream reader once its last byte (index 52) has arrived. The block tells the device whether a whole free slot exists. A cell that begins while no slot is free is discarded in full and counted. A start-of-cell in the middle of a cell abandons the partial cell and restarts in the same slot.

Every presented byte is also checked for odd parity. When parity monitoring is switched on, a bad byte sets a sticky status bit, which software clears by writing a one. A parity error never changes what is stored. The reader drains the queue one byte per request, with first-byte and last-byte markers.

Top module: `utp_tx_cell_if`

## Requirements
- R1: After reset `utx_room_o` is 1, `cq_valid_o` is 0, `par_err_sts_o` is 0 and `drop_cnt_o` is 0. `utx_room_o` is 1 exactly when fewer than FIFO_CELLS (default 4) complete cells are held.
- R2: A clock edge with `utx_en_i` low writes nothing and moves no framing state, whatever the data and start flag carry.
- R3: A byte with `utx_en_i` and `utx_soc_i` both high starts a new cell at index 0. If a cell was partly received, that partial cell is abandoned and never reaches the reader.
- R4: A cell becomes readable (`cq_valid_o` rises) on the edge that accepts its byte at index 52 (the 53rd byte), and not earlier.
- R5: Once a cell is committed, bytes with `utx_en_i` high but no start flag are ignored until the next start flag.
- R6: A start flag that arrives while `utx_room_o` is 0 discards that cell and the bytes that follow it up to the next start flag. `drop_cnt_o` increments by one, saturating at its all-ones value.
- R7: A presented byte has a parity error when the XOR of its 8 data bits and `utx_par_i` is 0 (odd parity expected). With `par_chk_en_i` high, such a byte sets `par_err_sts_o` on that edge.
- R8: A parity error does not alter the stored byte or the framing.
- R9: `par_err_sts_o` stays set until an edge with `sts_clr_i` high. A new error on the same edge as the clear leaves it set.
- R10: With `par_chk_en_i` low, parity errors never set `par_err_sts_o`.
- R11: The reader sees cells in arrival order and bytes in index order. `cq_first_o` is high on index 0, `cq_last_o` is high on index 52, and a read request while `cq_valid_o` is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running bus clock from the ATM device |
| rst_n | input | 1 | Active-low asynchronous reset |
| utx_en_i | input | 1 | Device is presenting a byte this cycle |
| utx_data_i | input | 8 | Cell byte |
| utx_par_i | input | 1 | Odd parity over `utx_data_i` |
| utx_soc_i | input | 1 | Marks byte 0 of a cell |
| utx_room_o | output | 1 | At least one whole cell slot is free |
| par_chk_en_i | input | 1 | Parity monitoring enable (acts as mask) |
| sts_clr_i | input | 1 | Write-one-to-clear strobe for the parity status |
| par_err_sts_o | output | 1 | Sticky parity error status |
| drop_cnt_o | output | DROP_W | Saturating count of discarded cells |
| cq_rd_i | input | 1 | Reader takes the current byte |
| cq_valid_o | output | 1 | A complete cell is available to read |
| cq_data_o | output | 8 | Current byte of the head cell |
| cq_first_o | output | 1 | Current byte is index 0 |
| cq_last_o | output | 1 | Current byte is index 52 |

## Verification
Parity is swept over all 256 data values with both parity bits, so a design that used even parity or skipped bytes outside a cell would flag the wrong half. The bench fills the queue, offers one more cell and then a few hundred extra start flags. A design that accepted a cell with no room would overwrite the oldest slot, and a counter without saturation would wrap to a small value. A partial cell followed by a fresh start flag, and stray bytes after a commit, catch a design that stores orphan bytes or shifts later cells. Set and clear on the same edge, and errors with monitoring off, catch a status bit that is not sticky or not masked.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [1:0] {
    FR_IDLE = 2'd0,
    FR_FILL = 2'd1,
    FR_DROP = 2'd2
  } fr_state_e;

  // 1 when the byte and its parity bit together hold an even number of ones
  function automatic logic odd_par_bad(input logic [7:0] d, input logic p);
    return ~(^{d, p});
  endfunction

  // flat byte address of a given index inside a given cell slot
  function automatic int unsigned slot_addr(input int unsigned slot,
                                            input int unsigned idx,
                                            input int unsigned cell_bytes);
    return slot * cell_bytes + idx;
  endfunction

endpackage

// File: rtl/txc_framer.sv
module txc_framer
  import txc_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int IDX_W      = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld_i,
  input  logic             soc_i,
  input  logic             room_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             commit_o,
  output logic             drop_o,
  output logic             abandon_o
);

  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  fr_state_e        state_q, state_d;
  logic [IDX_W-1:0] idx_q, idx_d;

  always_comb begin
    state_d   = state_q;
    idx_d     = idx_q;
    wr_en_o   = 1'b0;
    wr_idx_o  = idx_q;
    commit_o  = 1'b0;
    drop_o    = 1'b0;
    abandon_o = 1'b0;
    if (byte_vld_i) begin
      if (soc_i) begin
        abandon_o = (state_q == FR_FILL);
        if (room_i) begin
          wr_en_o  = 1'b1;
          wr_idx_o = '0;
          state_d  = FR_FILL;
          idx_d    = IDX_W'(1);
        end else begin
          drop_o  = 1'b1;
          state_d = FR_DROP;
          idx_d   = '0;
        end
      end else if (state_q == FR_FILL) begin
        wr_en_o  = 1'b1;
        wr_idx_o = idx_q;
        if (idx_q == LAST_IDX) begin
          commit_o = 1'b1;
          state_d  = FR_IDLE;
          idx_d    = '0;
        end else begin
          idx_d = idx_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FR_IDLE;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
    end
  end

endmodule

// File: rtl/txc_cell_fifo.sv
module txc_cell_fifo
  import txc_pkg::*;
#(
  parameter int CELL_BYTES = 53,
  parameter int FIFO_CELLS = 4,
  parameter int IDX_W      = 6,
  parameter int CNT_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [7:0]       wr_data_i,
  input  logic             commit_i,
  input  logic             rd_i,
  output logic             room_o,
  output logic             valid_o,
  output logic [7:0]       data_o,
  output logic             first_o,
  output logic             last_o,
  output logic             release_o,
  output logic [CNT_W-1:0] cell_cnt_o
);

  localparam int DEPTH  = CELL_BYTES * FIFO_CELLS;
  localparam int ADDR_W = $clog2(DEPTH);
  localparam int SLOT_W = (FIFO_CELLS > 1) ? $clog2(FIFO_CELLS) : 1;
  localparam logic [IDX_W-1:0]  LAST_IDX  = IDX_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(FIFO_CELLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(FIFO_CELLS);

  function automatic logic [SLOT_W-1:0] slot_inc(input logic [SLOT_W-1:0] s);
    return (s == LAST_SLOT) ? '0 : s + 1'b1;
  endfunction

  logic [7:0]        mem [DEPTH];
  logic [SLOT_W-1:0] wslot_q, rslot_q;
  logic [IDX_W-1:0]  rbyte_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic              pop;

  assign wr_addr    = ADDR_W'(slot_addr(32'(wslot_q), 32'(wr_idx_i), CELL_BYTES));
  assign rd_addr    = ADDR_W'(slot_addr(32'(rslot_q), 32'(rbyte_q), CELL_BYTES));
  assign valid_o    = (cnt_q != '0);
  assign pop        = rd_i && valid_o;
  assign data_o     = mem[rd_addr];
  assign first_o    = (rbyte_q == '0);
  assign last_o     = (rbyte_q == LAST_IDX);
  assign release_o  = pop && last_o;
  assign room_o     = (cnt_q < FULL_CNT);
  assign cell_cnt_o = cnt_q;

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr] <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wslot_q <= '0;
      rslot_q <= '0;
      rbyte_q <= '0;
      cnt_q   <= '0;
    end else begin
      if (commit_i) wslot_q <= slot_inc(wslot_q);
      if (pop) begin
        if (last_o) begin
          rbyte_q <= '0;
          rslot_q <= slot_inc(rslot_q);
        end else begin
          rbyte_q <= rbyte_q + 1'b1;
        end
      end
      case ({commit_i, release_o})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

endmodule

// File: rtl/txc_par_status.sv
module txc_par_status
  import txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       byte_vld_i,
  input  logic [7:0] data_i,
  input  logic       par_i,
  input  logic       chk_en_i,
  input  logic       clr_i,
  output logic       err_evt_o,
  output logic       sts_o
);

  logic sts_q;

  assign err_evt_o = byte_vld_i && odd_par_bad(data_i, par_i);
  assign sts_o     = sts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= 1'b0;
    else        sts_q <= (sts_q & ~clr_i) | (err_evt_o & chk_en_i);
  end

endmodule

// File: rtl/utp_tx_cell_if.sv
module utp_tx_cell_if #(
  parameter int CELL_BYTES = 53,
  parameter int FIFO_CELLS = 4,
  parameter int DROP_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              utx_en_i,
  input  logic [7:0]        utx_data_i,
  input  logic              utx_par_i,
  input  logic              utx_soc_i,
  output logic              utx_room_o,
  input  logic              par_chk_en_i,
  input  logic              sts_clr_i,
  output logic              par_err_sts_o,
  output logic [DROP_W-1:0] drop_cnt_o,
  input  logic              cq_rd_i,
  output logic              cq_valid_o,
  output logic [7:0]        cq_data_o,
  output logic              cq_first_o,
  output logic              cq_last_o
);

  localparam int IDX_W = $clog2(CELL_BYTES);
  localparam int CNT_W = $clog2(FIFO_CELLS + 1);

  // internal events, named for the checker
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             commit_evt;
  logic             drop_evt;
  logic             abandon_evt;
  logic             release_evt;
  logic             par_err_evt;
  logic [CNT_W-1:0] cell_cnt;
  logic [DROP_W-1:0] drop_q;

  txc_framer #(
    .CELL_BYTES(CELL_BYTES),
    .IDX_W     (IDX_W)
  ) u_framer (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld_i(utx_en_i),
    .soc_i     (utx_soc_i),
    .room_i    (utx_room_o),
    .wr_en_o   (wr_en),
    .wr_idx_o  (wr_idx),
    .commit_o  (commit_evt),
    .drop_o    (drop_evt),
    .abandon_o (abandon_evt)
  );

  txc_cell_fifo #(
    .CELL_BYTES(CELL_BYTES),
    .FIFO_CELLS(FIFO_CELLS),
    .IDX_W     (IDX_W),
    .CNT_W     (CNT_W)
  ) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (utx_data_i),
    .commit_i  (commit_evt),
    .rd_i      (cq_rd_i),
    .room_o    (utx_room_o),
    .valid_o   (cq_valid_o),
    .data_o    (cq_data_o),
    .first_o   (cq_first_o),
    .last_o    (cq_last_o),
    .release_o (release_evt),
    .cell_cnt_o(cell_cnt)
  );

  txc_par_status u_par (
    .clk       (clk),
    .rst_n     (rst_n),
    .byte_vld_i(utx_en_i),
    .data_i    (utx_data_i),
    .par_i     (utx_par_i),
    .chk_en_i  (par_chk_en_i),
    .clr_i     (sts_clr_i),
    .err_evt_o (par_err_evt),
    .sts_o     (par_err_sts_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          drop_q <= '0;
    else if (drop_evt && (drop_q != '1)) drop_q <= drop_q + 1'b1;
  end

  assign drop_cnt_o = drop_q;

endmodule

// File: rtl/utp_tx_cell_if_chk.sv
module utp_tx_cell_if_chk #(
  parameter int CELL_BYTES = 53,
  parameter int FIFO_CELLS = 4,
  parameter int DROP_W     = 8,
  parameter int IDX_W      = $clog2(CELL_BYTES),
  parameter int CNT_W      = $clog2(FIFO_CELLS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              room,
  input logic [CNT_W-1:0]  cell_cnt,
  input logic              commit_evt,
  input logic              release_evt,
  input logic              drop_evt,
  input logic [DROP_W-1:0] drop_cnt,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              sts,
  input logic              clr,
  input logic              chk_en,
  input logic              cq_valid
);

  // R1
  room_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !room |-> (cell_cnt == CNT_W'(FIFO_CELLS)));

  // R1
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_cnt == CNT_W'(FIFO_CELLS)) |-> !commit_evt);

  // R4
  commit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_evt |-> (wr_idx == IDX_W'(CELL_BYTES - 1)));

  // R6
  drop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_evt && (drop_cnt != '1)) |=> (drop_cnt == $past(drop_cnt) + 1'b1));

  // R6
  drop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !drop_evt |=> $stable(drop_cnt));

  // R9
  sts_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts && !clr) |=> sts);

  // R10
  sts_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sts && !chk_en) |=> !sts);

  // R11
  cnt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit_evt && !release_evt) |=> $stable(cell_cnt));

  // R11
  empty_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cq_valid |-> !release_evt);

endmodule

bind utp_tx_cell_if utp_tx_cell_if_chk #(
  .CELL_BYTES(CELL_BYTES),
  .FIFO_CELLS(FIFO_CELLS),
  .DROP_W    (DROP_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .room       (utx_room_o),
  .cell_cnt   (cell_cnt),
  .commit_evt (commit_evt),
  .release_evt(release_evt),
  .drop_evt   (drop_evt),
  .drop_cnt   (drop_cnt_o),
  .wr_idx     (wr_idx),
  .sts        (par_err_sts_o),
  .clr        (sts_clr_i),
  .chk_en     (par_chk_en_i),
  .cq_valid   (cq_valid_o)
);

// File: tb/tb_utp_tx_cell_if.sv
`timescale 1ns/1ps
module tb_utp_tx_cell_if;

  localparam int CB = 53;
  localparam int NC = 4;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          utx_en_i = 1'b0;
  logic [7:0]    utx_data_i = '0;
  logic          utx_par_i = 1'b0;
  logic          utx_soc_i = 1'b0;
  logic          utx_room_o;
  logic          par_chk_en_i = 1'b0;
  logic          sts_clr_i = 1'b0;
  logic          par_err_sts_o;
  logic [DW-1:0] drop_cnt_o;
  logic          cq_rd_i = 1'b0;
  logic          cq_valid_o;
  logic [7:0]    cq_data_o;
  logic          cq_first_o;
  logic          cq_last_o;

  int vectors = 0;
  int fails   = 0;

  always #2 clk = ~clk;

  utp_tx_cell_if #(.CELL_BYTES(CB), .FIFO_CELLS(NC), .DROP_W(DW)) dut (.*);

  function automatic logic [7:0] pat(input int seed, input int i);
    return 8'((seed * 37 + i * 11 + 5) & 255);
  endfunction

  function automatic logic good_par(input logic [7:0] d);
    int ones = 0;
    for (int b = 0; b < 8; b++) ones += int'(d[b]);
    return (ones % 2 == 0);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic p, input logic s);
    @(negedge clk);
    utx_en_i = 1'b1; utx_data_i = d; utx_par_i = p; utx_soc_i = s;
    @(posedge clk); #1;
    utx_en_i = 1'b0; utx_soc_i = 1'b0;
  endtask

  task automatic idle_junk(input logic [7:0] d);
    @(negedge clk);
    utx_en_i = 1'b0; utx_data_i = d; utx_par_i = 1'b0; utx_soc_i = 1'b1;
    @(posedge clk); #1;
    utx_soc_i = 1'b0;
  endtask

  task automatic send_cell(input int seed, input bit gaps, input int bad_idx,
                           input bit chk_commit);
    for (int i = 0; i < CB; i++) begin
      logic [7:0] d;
      d = pat(seed, i);
      if (chk_commit && i == CB - 1) check("R4 no cell before last byte", int'(cq_valid_o), 0);
      put(d, good_par(d) ^ (i == bad_idx), i == 0);
      if (gaps && (i % 5 == 2)) idle_junk(~d);
    end
    if (chk_commit) check("R4 cell visible after last byte", int'(cq_valid_o), 1);
  endtask

  task automatic read_cell(input int seed);
    for (int i = 0; i < CB; i++) begin
      @(negedge clk);
      check("R11 valid", int'(cq_valid_o), 1);
      check("R11 data",  int'(cq_data_o), int'(pat(seed, i)));
      check("R11 first", int'(cq_first_o), int'(i == 0));
      check("R11 last",  int'(cq_last_o), int'(i == CB - 1));
      cq_rd_i = 1'b1;
      @(posedge clk); #1;
      cq_rd_i = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 room at reset", int'(utx_room_o), 1);
    check("R1 valid at reset", int'(cq_valid_o), 0);
    check("R1 status at reset", int'(par_err_sts_o), 0);
    check("R1 drops at reset", int'(drop_cnt_o), 0);

    // R11 read with empty queue does nothing
    @(negedge clk); cq_rd_i = 1'b1; @(posedge clk); #1; cq_rd_i = 1'b0;

    // R2 R4 fill the queue, first cell with idle junk between bytes
    send_cell(1, 1'b1, -1, 1'b1);
    for (int c = 2; c <= NC; c++) begin
      check("R1 room before full", int'(utx_room_o), 1);
      send_cell(c, c == 3, -1, 1'b0);
    end
    check("R1 room when full", int'(utx_room_o), 0);

    // R6 cell offered with no room is discarded whole
    send_cell(50, 1'b0, -1, 1'b0);
    check("R6 drop count", int'(drop_cnt_o), 1);
    check("R6 still full", int'(utx_room_o), 0);

    // R11 drain in order; dropped cell absent
    read_cell(1);
    check("R1 room after one read", int'(utx_room_o), 1);
    for (int c = 2; c <= NC; c++) read_cell(c);
    @(negedge clk);
    check("R6 dropped cell not stored", int'(cq_valid_o), 0);

    // R3 partial cell abandoned by a new start
    for (int i = 0; i < 20; i++) put(pat(9, i), good_par(pat(9, i)), i == 0);
    send_cell(10, 1'b0, -1, 1'b0);
    read_cell(10);
    @(negedge clk);
    check("R3 partial cell absent", int'(cq_valid_o), 0);

    // R5 bytes after commit without start are ignored
    send_cell(11, 1'b0, -1, 1'b0);
    for (int i = 0; i < 10; i++) put(8'hA5, 1'b1, 1'b0);
    send_cell(12, 1'b0, -1, 1'b0);
    read_cell(11);
    read_cell(12);
    @(negedge clk);
    check("R5 no stray cell", int'(cq_valid_o), 0);

    // R10 monitoring off
    par_chk_en_i = 1'b0;
    send_cell(21, 1'b0, 5, 1'b0);
    check("R10 masked error", int'(par_err_sts_o), 0);
    read_cell(21);

    // R7 R8 monitoring on, error inside a stored cell
    par_chk_en_i = 1'b1;
    send_cell(20, 1'b0, 30, 1'b0);
    check("R7 status set", int'(par_err_sts_o), 1);
    read_cell(20);

    // R9 sticky across clean bytes, set beats clear
    put(8'h01, 1'b0, 1'b0);
    check("R9 sticky", int'(par_err_sts_o), 1);
    @(negedge clk);
    utx_en_i = 1'b1; utx_data_i = 8'h03; utx_par_i = 1'b0; sts_clr_i = 1'b1;
    @(posedge clk); #1;
    utx_en_i = 1'b0; sts_clr_i = 1'b0;
    check("R9 set beats clear", int'(par_err_sts_o), 1);
    @(negedge clk); sts_clr_i = 1'b1; @(posedge clk); #1; sts_clr_i = 1'b0;
    check("R9 clear", int'(par_err_sts_o), 0);

    // R7 exhaustive parity sweep, idle framing
    for (int d = 0; d < 256; d++) begin
      for (int p = 0; p < 2; p++) begin
        put(8'(d), 1'(p), 1'b0);
        check("R7 parity sweep", int'(par_err_sts_o),
              int'(good_par(8'(d)) != 1'(p)));
        @(negedge clk); sts_clr_i = 1'b1; @(posedge clk); #1; sts_clr_i = 1'b0;
      end
    end
    check("R8 sweep stored nothing", int'(cq_valid_o), 0);

    // R6 saturation
    for (int c = 0; c < NC; c++) send_cell(30 + c, 1'b0, -1, 1'b0);
    for (int i = 0; i < 300; i++) put(8'h5A, 1'b1, 1'b1);
    check("R6 drop saturates", int'(drop_cnt_o), 255);
    read_cell(30);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule